// File: doc/BRIEF.md
# Programmable Countdown Event Timer

This block is a down-counting timer that software programs through a small 32-bit register bus. Software writes a reload value as a low word and a high word. It then sets the enable bit together with the mode bits. The counter takes the reload value on that enable edge and counts down by one on every clock.

In one-shot mode the counter parks at zero. In periodic mode it reloads on the cycle after zero and runs on without help from software. A control bit joins the two words into a single 64-bit count; otherwise only the low word counts. Reaching zero sets a raw event flag. The flag is gated by an enable bit to drive a level interrupt line. Software clears the flag by writing a one to a clear bit.

The count can be read live at any time. A shadow pair gives a stable readback: reading the shadow low word also captures the high half of the count. A later read of the shadow high word then returns that captured half.

Top module: `evt_timer`

## Requirements
- R1: Registers are word-aligned at these byte offsets: 0x00 load low, 0x04 load high, 0x08 live count low, 0x0C live count high, 0x10 control, 0x14 interrupt, 0x18 shadow low, 0x1C shadow high. Read data appears on `rdata_o` one cycle after the read strobe. The load words and the control bits read back as written.
- R2: Control bit 1 is the enable. A control write that sets it while it was clear loads the counter from the load words in that same cycle.
- R3: While enabled, a nonzero count drops by exactly one per cycle. While disabled, the count holds its value.
- R4: Control bit 0 = 0 selects one-shot mode. The raw flag sets on the cycle the count reaches zero, which is L cycles after the enable write for a load value L ≥ 1. The count then stays at zero.
- R5: Control bit 0 = 1 selects periodic mode. At zero the counter reloads on the next cycle, so events repeat every L+1 cycles.
- R6: Control bit 16 = 0 selects 32-bit width. In that mode the load high word is ignored and the live high word reads 0.
- R7: Control bit 16 = 1 selects 64-bit width. The count spans both words, and the low word borrows from the high word.
- R8: The interrupt register holds the enable (bit 0), the raw flag (bit 1) and the masked flag (bit 2); the masked flag is raw AND enable. `irq_o` follows the masked flag.
- R9: Writing 1 to interrupt bit 3 clears the raw flag. If a new expiry happens in the same cycle, the raw flag stays set.
- R10: Reading shadow low returns the live low word and captures the live high word. Reading shadow high returns the captured value, even after the counter has moved on.
- R11: After reset every register, the count and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Registered read data |
| irq_o | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
On every cycle the assertions check the counter's stepping: decrement by one, holding while disabled, parking at zero in one-shot mode and reloading in periodic mode. They also check that the raw flag rises only together with a zero count, that a colliding clear never drops an event, and that the interrupt line never rises while its enable is off. The exact number of cycles from enable to event, the period across a sweep of load values, the borrow between words and the shadow snapshot against a moving count are visible only in the bench's scenarios.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // register select, taken from byte address bits [4:2]
   typedef enum logic [2:0] {
      SEL_LOAD_LO = 3'd0,
      SEL_LOAD_HI = 3'd1,
      SEL_VAL_LO  = 3'd2,
      SEL_VAL_HI  = 3'd3,
      SEL_CTRL    = 3'd4,
      SEL_INT     = 3'd5,
      SEL_SHD_LO  = 3'd6,
      SEL_SHD_HI  = 3'd7
   } reg_sel_e;

   // control word bit positions
   localparam int CTL_PERIODIC = 0;
   localparam int CTL_ENABLE   = 1;
   localparam int CTL_WIDE     = 16;

   // interrupt word bit positions
   localparam int INT_EN  = 0;
   localparam int INT_RAW = 1;
   localparam int INT_MSK = 2;
   localparam int INT_CLR = 3;

   localparam int ADDR_W = 5;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int WIDE_EN = 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_i,
   input  logic                  rd_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [WORD_W-1:0]     wdata_i,
   input  logic [2*WORD_W-1:0]   cnt_i,
   input  logic                  raw_i,
   input  logic                  ie_i,
   output logic [WORD_W-1:0]     rdata_o,
   output logic [WORD_W-1:0]     load_lo_o,
   output logic [WORD_W-1:0]     load_hi_o,
   output logic                  run_o,
   output logic                  per_o,
   output logic                  wide_o,
   output logic                  load_now_o,
   output logic                  load_wide_o,
   output logic                  int_wr_o
);

   localparam logic WIDE_OK = (WIDE_EN != 0);

   reg_sel_e          sel;
   logic              hit;
   logic              wr_hit, rd_hit;
   logic [WORD_W-1:0] load_lo_q, load_hi_q, shd_hi_q, rdata_q, rd_val;
   logic              run_q, per_q, wide_q;

   assign sel    = reg_sel_e'(addr_i[4:2]);
   assign hit    = (addr_i[1:0] == 2'b00);
   assign wr_hit = wr_i & hit;
   assign rd_hit = rd_i & hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         load_lo_q <= '0;
         load_hi_q <= '0;
         run_q     <= 1'b0;
         per_q     <= 1'b0;
         wide_q    <= 1'b0;
      end else if (wr_hit) begin
         case (sel)
            SEL_LOAD_LO: load_lo_q <= wdata_i;
            SEL_LOAD_HI: load_hi_q <= wdata_i;
            SEL_CTRL: begin
               per_q  <= wdata_i[CTL_PERIODIC];
               run_q  <= wdata_i[CTL_ENABLE];
               wide_q <= WIDE_OK & wdata_i[CTL_WIDE];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_val = '0;
      case (sel)
         SEL_LOAD_LO: rd_val = load_lo_q;
         SEL_LOAD_HI: rd_val = load_hi_q;
         SEL_VAL_LO:  rd_val = cnt_i[WORD_W-1:0];
         SEL_VAL_HI:  rd_val = cnt_i[2*WORD_W-1:WORD_W];
         SEL_CTRL: begin
            rd_val[CTL_PERIODIC] = per_q;
            rd_val[CTL_ENABLE]   = run_q;
            rd_val[CTL_WIDE]     = wide_q;
         end
         SEL_INT: begin
            rd_val[INT_EN]  = ie_i;
            rd_val[INT_RAW] = raw_i;
            rd_val[INT_MSK] = raw_i & ie_i;
         end
         SEL_SHD_LO:  rd_val = cnt_i[WORD_W-1:0];
         SEL_SHD_HI:  rd_val = shd_hi_q;
         default:     rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q  <= '0;
         shd_hi_q <= '0;
      end else if (rd_i) begin
         rdata_q <= rd_hit ? rd_val : '0;
         if (rd_hit && sel == SEL_SHD_LO)
            shd_hi_q <= cnt_i[2*WORD_W-1:WORD_W];
      end
   end

   assign rdata_o     = rdata_q;
   assign load_lo_o   = load_lo_q;
   assign load_hi_o   = load_hi_q;
   assign run_o       = run_q;
   assign per_o       = per_q;
   assign wide_o      = wide_q;
   assign load_now_o  = wr_hit && sel == SEL_CTRL && wdata_i[CTL_ENABLE] && !run_q;
   assign load_wide_o = WIDE_OK & wdata_i[CTL_WIDE];
   assign int_wr_o    = wr_hit && sel == SEL_INT;

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
   parameter int WORD_W  = 32,
   parameter int WIDE_EN = 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_now_i,
   input  logic                  load_wide_i,
   input  logic                  run_i,
   input  logic                  per_i,
   input  logic                  wide_i,
   input  logic [WORD_W-1:0]     load_lo_i,
   input  logic [WORD_W-1:0]     load_hi_i,
   output logic [2*WORD_W-1:0]   cnt_o,
   output logic                  expire_o
);

   localparam int              CW    = (WIDE_EN != 0) ? 2*WORD_W : WORD_W;
   localparam logic [CW-1:0]   C_ONE = CW'(1);

   logic [CW-1:0] c_q, ld_new, ld_rel;

   generate
      if (WIDE_EN != 0) begin : g_wide
         assign ld_new = load_wide_i ? {load_hi_i, load_lo_i} : {{WORD_W{1'b0}}, load_lo_i};
         assign ld_rel = wide_i      ? {load_hi_i, load_lo_i} : {{WORD_W{1'b0}}, load_lo_i};
         assign cnt_o  = c_q;
      end else begin : g_narrow
         assign ld_new = load_lo_i;
         assign ld_rel = load_lo_i;
         assign cnt_o  = {{WORD_W{1'b0}}, c_q};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         c_q <= '0;
      end else if (load_now_i) begin
         c_q <= ld_new;
      end else if (run_i) begin
         if (c_q == '0) begin
            if (per_i) c_q <= ld_rel;
         end else begin
            c_q <= c_q - C_ONE;
         end
      end
   end

   // the count reaches zero at the coming edge
   assign expire_o = run_i && !load_now_i && (c_q == C_ONE);

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic int_wr_i,
   input  logic en_bit_i,
   input  logic clr_bit_i,
   input  logic expire_i,
   output logic clr_o,
   output logic raw_o,
   output logic ie_o,
   output logic irq_o
);

   logic raw_q, ie_q;

   assign clr_o = int_wr_i & clr_bit_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ie_q  <= 1'b0;
         raw_q <= 1'b0;
      end else begin
         if (int_wr_i) ie_q <= en_bit_i;
         if (expire_i)   raw_q <= 1'b1;
         else if (clr_o) raw_q <= 1'b0;
      end
   end

   assign raw_o = raw_q;
   assign ie_o  = ie_q;
   assign irq_o = raw_q & ie_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int WIDE_EN = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [4:0]        addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              irq_o
);

   generate
      if (WORD_W < CTL_WIDE + 1) begin : g_bad_word
         $error("evt_timer: WORD_W must hold control bit 16");
      end
      if (WIDE_EN != 0 && WIDE_EN != 1) begin : g_bad_wide
         $error("evt_timer: WIDE_EN must be 0 or 1");
      end
   endgenerate

   logic [2*WORD_W-1:0] cnt_w;
   logic [WORD_W-1:0]   load_lo_w, load_hi_w;
   logic run_w, per_w, wide_w, load_now_w, load_wide_w, int_wr_w;
   logic expire_w, clr_w, raw_w, ie_w;

   evt_timer_regs #(.WORD_W(WORD_W), .WIDE_EN(WIDE_EN)) i_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_i),
      .rd_i        (rd_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .cnt_i       (cnt_w),
      .raw_i       (raw_w),
      .ie_i        (ie_w),
      .rdata_o     (rdata_o),
      .load_lo_o   (load_lo_w),
      .load_hi_o   (load_hi_w),
      .run_o       (run_w),
      .per_o       (per_w),
      .wide_o      (wide_w),
      .load_now_o  (load_now_w),
      .load_wide_o (load_wide_w),
      .int_wr_o    (int_wr_w)
   );

   evt_timer_counter #(.WORD_W(WORD_W), .WIDE_EN(WIDE_EN)) i_counter (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_now_i  (load_now_w),
      .load_wide_i (load_wide_w),
      .run_i       (run_w),
      .per_i       (per_w),
      .wide_i      (wide_w),
      .load_lo_i   (load_lo_w),
      .load_hi_i   (load_hi_w),
      .cnt_o       (cnt_w),
      .expire_o    (expire_w)
   );

   evt_timer_irq i_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .int_wr_i  (int_wr_w),
      .en_bit_i  (wdata_i[INT_EN]),
      .clr_bit_i (wdata_i[INT_CLR]),
      .expire_i  (expire_w),
      .clr_o     (clr_w),
      .raw_o     (raw_w),
      .ie_o      (ie_w),
      .irq_o     (irq_o)
   );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int WORD_W = 32
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                irq_o,
   input logic [2*WORD_W-1:0] cnt,
   input logic [WORD_W-1:0]   load_lo,
   input logic [WORD_W-1:0]   load_hi,
   input logic                run,
   input logic                per,
   input logic                wide,
   input logic                load_now,
   input logic                expire,
   input logic                clr,
   input logic                raw,
   input logic                ie
);

   localparam logic [2*WORD_W-1:0] K_ONE = (2*WORD_W)'(1);

   logic [2*WORD_W-1:0] reload_val;
   assign reload_val = wide ? {load_hi, load_lo} : {{WORD_W{1'b0}}, load_lo};

   assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt != '0) |=> cnt == $past(cnt) - K_ONE);

   assert_hold_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !load_now) |=> $stable(cnt));

   assert_park_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && !per && cnt == '0) |=> cnt == '0);

   assert_raw_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw) |-> cnt == '0);

   assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && per && cnt == '0) |=> cnt == $past(reload_val));

   assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (ie && raw));

   assert_clear_collide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire && clr) |=> raw);

endmodule

bind evt_timer evt_timer_chk #(.WORD_W(WORD_W)) i_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .irq_o    (irq_o),
   .cnt      (cnt_w),
   .load_lo  (load_lo_w),
   .load_hi  (load_hi_w),
   .run      (run_w),
   .per      (per_w),
   .wide     (wide_w),
   .load_now (load_now_w),
   .expire   (expire_w),
   .clr      (clr_w),
   .raw      (raw_w),
   .ie       (ie_w)
);

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;

   localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_VLO = 5'h08, A_VHI = 5'h0C,
                          A_CTL = 5'h10, A_INT = 5'h14, A_SLO = 5'h18, A_SHI = 5'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   logic [31:0] v, v2;
   int          n;

   always #2.5 clk = ~clk;

   evt_timer i_evt_timer (
      .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic wait_irq(output int cycles);
      cycles = 0;
      while (!irq && cycles < 60) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk("R11 irq", irq, 0);
      bus_rd(A_CTL, v); chk("R11 ctrl", v, 0);
      bus_rd(A_VLO, v); chk("R11 value", v, 0);
      bus_rd(A_INT, v); chk("R11 int", v, 0);

      // R1 readback
      bus_wr(A_LLO, 32'hA5A5_1234);
      bus_wr(A_LHI, 32'h0F0F_0001);
      bus_wr(A_CTL, 32'h0001_0001);
      bus_rd(A_LLO, v); chk("R1 load lo", v, 32'hA5A5_1234);
      bus_rd(A_LHI, v); chk("R1 load hi", v, 32'h0F0F_0001);
      bus_rd(A_CTL, v); chk("R1 ctrl", v, 32'h0001_0001);

      // R2 / R3 load, count, freeze, reload
      bus_wr(A_CTL, 0);
      bus_wr(A_LLO, 100);
      bus_wr(A_CTL, 32'h2);
      bus_wr(A_CTL, 32'h0);
      bus_rd(A_VLO, v); chk("R3 one step", v, 99);
      repeat (5) @(negedge clk);
      bus_rd(A_VLO, v); chk("R3 frozen", v, 99);
      bus_wr(A_CTL, 32'h2);
      bus_rd(A_VLO, v); chk("R2 reload on enable", v, 100);

      // R6 narrow mode ignores high word
      bus_wr(A_CTL, 0);
      bus_wr(A_LHI, 5);
      bus_wr(A_LLO, 3);
      bus_wr(A_CTL, 32'h2);
      bus_rd(A_VHI, v); chk("R6 high reads zero", v, 0);
      bus_rd(A_VLO, v); chk("R6 low counts", v, 2);

      // R4 one-shot sweep
      bus_wr(A_INT, 32'h9);
      for (int l = 1; l <= 8; l++) begin
         bus_wr(A_CTL, 0);
         bus_wr(A_INT, 32'h9);
         bus_wr(A_LHI, 0);
         bus_wr(A_LLO, l);
         bus_wr(A_CTL, 32'h2);
         wait_irq(n);
         chk($sformatf("R4 oneshot delay L=%0d", l), n, l);
         bus_rd(A_VLO, v);
         repeat (3) @(negedge clk);
         bus_rd(A_VLO, v2);
         chk("R4 parks at zero", {v, v2}, 0);
         bus_wr(A_INT, 32'h9);
         chk("R9 clear drops irq", irq, 0);
      end

      // R5 periodic sweep
      for (int l = 1; l <= 6; l++) begin
         bus_wr(A_CTL, 0);
         bus_wr(A_INT, 32'h9);
         bus_wr(A_LLO, l);
         bus_wr(A_CTL, 32'h3);
         wait_irq(n);
         chk($sformatf("R5 first event L=%0d", l), n, l);
         bus_wr(A_INT, 32'h9);
         wait_irq(n);
         chk($sformatf("R5 period L=%0d", l), n, l);
      end

      // R8 masking
      bus_wr(A_CTL, 0);
      bus_wr(A_INT, 32'h8);
      bus_wr(A_LLO, 3);
      bus_wr(A_CTL, 32'h2);
      repeat (5) @(negedge clk);
      chk("R8 masked irq low", irq, 0);
      bus_rd(A_INT, v); chk("R8 raw only", v, 32'h2);
      bus_wr(A_INT, 32'h1);
      chk("R8 irq after enable", irq, 1);
      bus_rd(A_INT, v); chk("R8 all bits", v, 32'h7);

      // R9 clear colliding with expiry
      bus_wr(A_CTL, 0);
      bus_wr(A_INT, 32'h9);
      bus_wr(A_LLO, 4);
      bus_wr(A_CTL, 32'h2);
      repeat (3) @(negedge clk);
      bus_wr(A_INT, 32'h9);
      chk("R9 collision keeps irq", irq, 1);
      bus_rd(A_INT, v); chk("R9 collision raw", v, 32'h7);

      // R7 / R10 wide mode borrow and shadow snapshot
      bus_wr(A_CTL, 0);
      bus_wr(A_INT, 32'h9);
      bus_wr(A_LLO, 0);
      bus_wr(A_LHI, 1);
      bus_wr(A_CTL, 32'h0001_0002);
      bus_rd(A_SLO, v); chk("R10 shadow low", v, 0);
      bus_rd(A_VHI, v); chk("R7 high borrowed", v, 0);
      bus_rd(A_SHI, v); chk("R10 shadow high snapshot", v, 1);
      bus_rd(A_VLO, v); chk("R7 low after borrow", v, 32'hFFFF_FFFD);
      bus_wr(A_CTL, 0);

      finish_run();
   end

endmodule